// File: doc/BRIEF.md
# Interrupt Source Routing Multiplexer

This block steers sixteen peripheral event lines onto the twelve maskable CPU interrupt inputs INT4 to INT15. Each CPU line has its own 4-bit selector, and the selector holds the code of the source that drives that line. The selectors live in two 32-bit words. Software writes and reads these words through a small memory-mapped port. The routed outputs are pure combinational muxes fed by the registered selectors. Edge qualification, polarity, flagging and priority are handled by the blocks that sit after this one.

The source codes are fixed. Code 0 is the host-port event, codes 1 and 2 are timers 0 and 1, code 3 is memory refresh, codes 4 to 7 are external pins 4 to 7, and codes 8 to 11 are DMA channels 0 to 3. Codes 12 and 13 are serial port 0 transmit and receive, and codes 14 and 15 are serial port 1 transmit and receive. Bit n of `src_evt` carries source code n. Bit k of `cpu_irq` drives CPU line INT(k+4).

Top module: `irq_route_mux`

## Requirements
- R1: After reset, each CPU line INTn (n = 4..15) selects source code n-4, so `cpu_irq[k]` follows `src_evt[k]` for k = 0..11. Sources 12..15 drive no line.
- R2: The word at byte offset 0 holds the selectors for INT10..INT15. The word at byte offset 4 holds the selectors for INT4..INT9. A write changes only the word it addresses. A write to any other offset changes nothing, and a read from any other offset returns zero.
- R3: Within each word, the selectors for the six lines, in ascending line order, sit at bits [3:0], [8:5], [13:10], [19:16], [24:21] and [29:26]. Readback returns each selector at its own position.
- R4: Bits 4, 9, 14, 15, 20, 25, 30 and 31 of either word are reserved. They ignore written data and read back as zero.
- R5: A read request `rd_en` produces `rdata` and a one-cycle `rdata_vld` pulse on the following cycle. Without a request, `rdata_vld` is low and `rdata` holds its value. A read in the same cycle as a write to the same word returns the value from before the write. `rdata` is zero after reset.
- R6: Routing is combinational. A change on `src_evt` reaches `cpu_irq` in the same cycle, without a clock edge.
- R7: A selector that holds code c routes `src_evt[c]`. For example, code 5 in the INT12 selector (high word, bits [13:10]) routes external pin 5 to `cpu_irq[8]`.
- R8: Several lines may select the same source code, and each of them then carries that source's event.
- R9: A selector write takes effect on the routed outputs from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selector words |
| rd_en | input | 1 | Read request |
| addr | input | 4 | Byte offset: 0 is the high word, 4 is the low word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rdata_vld | output | 1 | Pulses for one cycle, one cycle after `rd_en` |
| src_evt | input | 16 | Peripheral event lines; bit n carries source code n |
| cpu_irq | output | 12 | Routed lines; bit k drives CPU interrupt INT(k+4) |

## Verification
The embedded properties check the following on every cycle:
- read latency and pulse shape;
- that `rdata` holds between reads;
- that reserved readback bits are zero;
- that a word keeps its selectors when it is not addressed;
- that lines sharing a selector code carry equal values.

The field placement, the reset map, the decoding of source codes and the ordering of a read with a write in the same cycle can only be shown by the bench scenarios. The bench compares every cycle against a behavioural model, and it also checks hand-computed words such as an all-ones write reading back as 0x3DEF3DEF.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   // Selectors sit SEL_W+1 apart, with one extra gap bit before the upper half of the fields.
   function automatic int fld_lsb(input int idx, input int sel_w, input int fields);
      return idx * (sel_w + 1) + ((idx >= fields / 2) ? 1 : 0);
   endfunction

   // Ones at every bit that belongs to a selector field.
   function automatic logic [63:0] fld_mask(input int sel_w, input int fields);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < fields; i++) begin
         for (int b = 0; b < sel_w; b++) begin
            m[fld_lsb(i, sel_w, fields) + b] = 1'b1;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/irq_sel_bank.sv
module irq_sel_bank
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC   = 16,
   parameter int SEL_W     = 4,
   parameter int FIELDS    = 6,
   parameter int DATA_W    = 32,
   parameter int BASE_LINE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [DATA_W-1:0]       wdata,
   output logic [FIELDS*SEL_W-1:0] sel_flat,
   output logic [DATA_W-1:0]       word_o
);

   localparam logic [DATA_W-1:0] FMASK = DATA_W'(fld_mask(SEL_W, FIELDS));

   if (fld_lsb(FIELDS - 1, SEL_W, FIELDS) + SEL_W > DATA_W) begin : g_bad_fit
      $error("irq_sel_bank: selector fields do not fit in DATA_W");
   end
   if (DATA_W > 64) begin : g_bad_width
      $error("irq_sel_bank: DATA_W above 64 is not supported");
   end

   for (genvar i = 0; i < FIELDS; i++) begin : g_fld
      localparam int               LSB = fld_lsb(i, SEL_W, FIELDS);
      localparam logic [SEL_W-1:0] RST = SEL_W'((BASE_LINE + i) % NUM_SRC);
      logic [SEL_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RST;
         end else if (wr_en) begin
            q <= wdata[LSB +: SEL_W];
         end
      end

      assign sel_flat[i*SEL_W +: SEL_W] = q;
   end

   always_comb begin
      word_o = '0;
      for (int i = 0; i < FIELDS; i++) begin
         word_o[fld_lsb(i, SEL_W, FIELDS) +: SEL_W] = sel_flat[i*SEL_W +: SEL_W];
      end
   end

   logic unused_rsvd_bits;
   assign unused_rsvd_bits = ^(wdata & ~FMASK);

   // R2: a bank that is not written keeps every selector
   assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(sel_flat));

endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar #(
   parameter int NUM_SRC   = 16,
   parameter int SEL_W     = 4,
   parameter int NUM_LINES = 12
) (
   input  logic [NUM_SRC-1:0]         src_evt,
   input  logic [NUM_LINES*SEL_W-1:0] sel_flat,
   output logic [NUM_LINES-1:0]       irq_o
);

   if (NUM_SRC > (1 << SEL_W)) begin : g_bad_sel
      $error("irq_route_xbar: SEL_W too narrow for NUM_SRC");
   end

   for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
      logic [SEL_W-1:0] sel;
      assign sel = sel_flat[k*SEL_W +: SEL_W];
      if (NUM_SRC == (1 << SEL_W)) begin : g_full
         assign irq_o[k] = src_evt[sel];
      end else begin : g_guard
         assign irq_o[k] = (int'(sel) < NUM_SRC) ? src_evt[sel] : 1'b0;
      end
   end

   // R8: lines that share a selector code carry the same event
   always_comb begin
      for (int a = 0; a < NUM_LINES; a++) begin
         for (int b = a + 1; b < NUM_LINES; b++) begin
            if (sel_flat[a*SEL_W +: SEL_W] == sel_flat[b*SEL_W +: SEL_W]) begin
               assert_shared_src_R8: assert (irq_o[a] === irq_o[b]);
            end
         end
      end
   end

endmodule

// File: rtl/irq_readback.sv
module irq_readback #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int HI_OFF = 0,
   parameter int LO_OFF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] hi_word,
   input  logic [DATA_W-1:0] lo_word,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_vld
);

   logic [DATA_W-1:0] sel_word;

   always_comb begin
      if (addr == ADDR_W'(HI_OFF)) begin
         sel_word = hi_word;
      end else if (addr == ADDR_W'(LO_OFF)) begin
         sel_word = lo_word;
      end else begin
         sel_word = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata     <= '0;
         rdata_vld <= 1'b0;
      end else begin
         rdata_vld <= rd_en;
         if (rd_en) begin
            rdata <= sel_word;
         end
      end
   end

   // R5: every request yields a valid pulse on the next cycle
   assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rdata_vld);

   // R5: with no request, there is no pulse and the data holds
   assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (!rdata_vld && $stable(rdata)));

endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int SEL_W   = 4,
   parameter int FIELDS  = 6,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4,
   parameter int HI_OFF  = 0,
   parameter int LO_OFF  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic                 rdata_vld,
   input  logic [NUM_SRC-1:0]   src_evt,
   output logic [2*FIELDS-1:0]  cpu_irq
);

   localparam int                NUM_LINES = 2 * FIELDS;
   localparam int                BANK_W    = FIELDS * SEL_W;
   localparam logic [DATA_W-1:0] RSVD      = ~DATA_W'(fld_mask(SEL_W, FIELDS));

   if (HI_OFF == LO_OFF) begin : g_bad_map
      $error("irq_route_mux: the two words need distinct offsets");
   end
   if (HI_OFF >= (1 << ADDR_W) || LO_OFF >= (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_route_mux: offset out of ADDR_W range");
   end

   logic              wr_hi, wr_lo;
   logic [BANK_W-1:0] hi_sel, lo_sel;
   logic [DATA_W-1:0] hi_word, lo_word;

   assign wr_hi = wr_en && (addr == ADDR_W'(HI_OFF));
   assign wr_lo = wr_en && (addr == ADDR_W'(LO_OFF));

   // low word: lines INT4.. ; high word: following lines
   irq_sel_bank #(
      .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .FIELDS(FIELDS), .DATA_W(DATA_W), .BASE_LINE(0)
   ) lo_bank_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_lo), .wdata(wdata),
      .sel_flat(lo_sel), .word_o(lo_word)
   );

   irq_sel_bank #(
      .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .FIELDS(FIELDS), .DATA_W(DATA_W), .BASE_LINE(FIELDS)
   ) hi_bank_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hi), .wdata(wdata),
      .sel_flat(hi_sel), .word_o(hi_word)
   );

   irq_route_xbar #(
      .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .NUM_LINES(NUM_LINES)
   ) xbar_i (
      .src_evt(src_evt), .sel_flat({hi_sel, lo_sel}), .irq_o(cpu_irq)
   );

   irq_readback #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HI_OFF(HI_OFF), .LO_OFF(LO_OFF)
   ) rdbk_i (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
      .hi_word(hi_word), .lo_word(lo_word), .rdata(rdata), .rdata_vld(rdata_vld)
   );

   // R4: reserved bit positions never read back as one
   assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_vld |-> ((rdata & RSVD) == '0));

   // R2: a write to any address other than the low word leaves low selectors alone
   assert_lo_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != ADDR_W'(LO_OFF)) |=> $stable(lo_sel));

   // R2: a write to any address other than the high word leaves high selectors alone
   assert_hi_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != ADDR_W'(HI_OFF)) |=> $stable(hi_sel));

endmodule

// File: tb/irq_route_mux_tb.sv
`timescale 1ns/1ps
module irq_route_mux_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rdata_vld;
   logic [15:0] src_evt = '0;
   logic [11:0] cpu_irq;

   int n_chk = 0;
   int n_err = 0;
   int cycles = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_route_mux dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld),
      .src_evt(src_evt), .cpu_irq(cpu_irq)
   );

   // behavioural reference model
   int          offs[6] = '{0, 5, 10, 16, 21, 26};
   int          msel[12];
   logic [31:0] m_rdata = '0;
   logic        m_vld = 1'b0;

   function automatic logic [31:0] model_word(int base);
      logic [31:0] w = '0;
      for (int j = 0; j < 6; j++) w = w | (32'(msel[base + j] & 15) << offs[j]);
      return w;
   endfunction

   function automatic logic [31:0] seq_word(int first);
      logic [31:0] w = '0;
      for (int j = 0; j < 6; j++) w = w | (32'(first + j) << offs[j]);
      return w;
   endfunction

   initial for (int k = 0; k < 12; k++) msel[k] = k;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!rst_n) begin
         for (int k = 0; k < 12; k++) msel[k] = k;
         m_rdata = '0;
         m_vld   = 1'b0;
      end else begin
         m_vld = rd_en;
         if (rd_en) m_rdata = (addr == 4'd0) ? model_word(6) :
                              (addr == 4'd4) ? model_word(0) : 32'h0;
         if (wr_en && (addr == 4'd0 || addr == 4'd4)) begin
            for (int j = 0; j < 6; j++)
               msel[(addr == 4'd0 ? 6 : 0) + j] = int'((wdata >> offs[j]) & 32'hF);
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [11:0] exp_irq;
         for (int k = 0; k < 12; k++) exp_irq[k] = src_evt[msel[k]];
         check("R6 per-cycle cpu_irq", 32'(cpu_irq), 32'(exp_irq));
         check("R5 per-cycle rdata_vld", 32'(rdata_vld), 32'(m_vld));
         check("R5 per-cycle rdata", rdata, m_rdata);
      end
   end

   task automatic do_write(logic [3:0] a, logic [31:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic do_read(logic [3:0] a, output logic [31:0] d);
      @(posedge clk); #2;
      rd_en = 1'b1; addr = a;
      @(posedge clk); #2;
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic route(logic [15:0] s, logic [11:0] exp, string tag);
      src_evt = s;
      #1;
      check(tag, 32'(cpu_irq), 32'(exp));
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cycles > 100000 && !done) begin
         n_err++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #2;
      check("R5 reset rdata", rdata, 32'h0);
      check("R5 reset rdata_vld", 32'(rdata_vld), 32'h0);
      rst_n = 1'b1;

      // R1: reset map, one source at a time
      for (int k = 0; k < 16; k++)
         route(16'(1 << k), (k < 12) ? 12'(1 << k) : 12'h0, "R1 reset routing");
      do_read(4'd0, d); check("R1 high word reset", d, seq_word(6));
      do_read(4'd4, d); check("R1 low word reset", d, seq_word(0));

      // R7/R9: pin 5 onto INT12
      route(16'h0020, 12'h020, "R9 before write");
      do_write(4'd0, 32'h2D4914E6);
      route(16'h0020, 12'h120, "R7 R9 code 5 in INT12 selector");
      do_read(4'd0, d); check("R2 high word readback", d, 32'h2D4914E6);

      // R4/R8: all ones to low word
      do_write(4'd4, 32'hFFFFFFFF);
      do_read(4'd4, d); check("R4 reserved bits read zero", d, 32'h3DEF3DEF);
      route(16'h8000, 12'h03F, "R8 shared source fan-out");

      // R2: unmapped offset
      do_write(4'd8, 32'h0);
      do_read(4'd4, d); check("R2 unmapped write ignored", d, 32'h3DEF3DEF);
      do_read(4'd8, d); check("R2 unmapped read zero", d, 32'h0);
      do_read(4'd0, d); check("R2 high word untouched", d, 32'h2D4914E6);

      // R3: distinct codes per field
      do_write(4'd4, 32'h1DC5306A);
      do_read(4'd4, d); check("R3 field positions", d, 32'h1DC5306A);
      route(16'h1000, 12'h004, "R3 code 12 on INT6");
      route(16'h0200, 12'h200, "R3 R7 code 9 on INT13");

      // R5: read and write in the same cycle
      @(posedge clk); #2;
      rd_en = 1'b1; wr_en = 1'b1; addr = 4'd4; wdata = 32'h0;
      @(posedge clk); #2;
      rd_en = 1'b0; wr_en = 1'b0;
      check("R5 read sees old word", rdata, 32'h1DC5306A);
      check("R5 valid pulse", 32'(rdata_vld), 32'h1);
      @(posedge clk); #2;
      check("R5 valid drops", 32'(rdata_vld), 32'h0);
      check("R5 rdata holds", rdata, 32'h1DC5306A);
      do_read(4'd4, d); check("R5 write landed", d, 32'h0);

      // R6: combinational path inside one cycle
      route(16'h0000, 12'h000, "R6 no event");
      route(16'h0001, 12'h03F, "R6 event without clock");

      // R4: reserved bits mixed into a write
      do_write(4'd4, 32'hDFD5F27A);
      do_read(4'd4, d); check("R4 reserved writes dropped", d, 32'h1DC5306A);

      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule